// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This unit executes one add, subtract, logical left shift or logical right shift on two operands at an 8-, 16- or 32-bit operand size. The result appears combinationally on the same cycle. The status flags for that result are latched into a 16-bit flags word on the next clock edge. Six arithmetic flags are produced:

- carry or borrow
- signed overflow
- sign
- zero
- nibble carry (carry from bit 3 into bit 4)
- odd population parity

Three control flags (direction, interrupt enable, trap) live in the same word. Arithmetic never touches them, and only a separate load strobe can write them.

A surrounding execution pipeline drives an operation with `opValid` high when it wants the flags to follow that result. It holds `opValid` low when it only wants the result value. The flags word is read directly by whatever evaluates conditions.

Top module: `statusFlagUnit`

## Requirements
- R1: While `rstN` is low, and after its release until the first update, `flagsWord` reads 16'h0000.
- R2: `opCode` selects the operation: 00 add, 01 subtract (srcA minus srcB), 10 logical left shift, 11 logical right shift. Shifts move srcA by the count `srcB[4:0]`. `opSize` selects the width: 00 is 8 bits, 01 is 16 bits, 10 and 11 are 32 bits. Operands and result use only the low bits of that width. Add and subtract wrap modulo 2^width. `result` bits above the width read 0.
- R3: Flag CF is set as follows:
  - add: the carry out of the top bit of the active width.
  - subtract: 1 exactly when srcA is below srcB as unsigned values at that width.
  - shift: the last bit moved out of the operand. This is 0 when the count exceeds the width.
- R4: Flag OF is set as follows:
  - add: 1 when both operands share a sign and the result sign differs from it.
  - subtract: 1 when the operand signs differ and the result sign differs from srcA.
  - shift: 0.
- R5: SF equals the top bit of the result at the active width. ZF is 1 exactly when the result at that width is zero.
- R6: AF is 1 when an add carries, or a subtract borrows, from bit 3 into bit 4. For shifts AF is 0.
- R7: PF is 1 when the result at the active width holds an odd number of 1 bits, and 0 when even.
- R8: The bit positions in `flagsWord` are CF 0, PF 2, AF 4, ZF 6, SF 7, TF 8, IF 9, DF 10 and OF 11. Bits 1, 3, 5 and 12 to 15 always read 0.
- R9: The arithmetic flags take the values for the current inputs at a rising edge where `opValid` is high. They are readable after that edge, and they keep their value at every other edge.
- R10: A shift with a count of zero leaves all arithmetic flags unchanged, even with `opValid` high.
- R11: At a rising edge with `ctlLoad` high, DF, IF and TF take `ctlData[2]`, `ctlData[1]` and `ctlData[0]`. At all other edges they hold, whatever operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Capture the arithmetic flags of this operation at the next edge |
| opCode | input | 2 | Operation select |
| opSize | input | 2 | Operand width select |
| srcA | input | 32 | First operand / value to shift |
| srcB | input | 32 | Second operand / shift count in bits 4:0 |
| ctlLoad | input | 1 | Write the three control flags at the next edge |
| ctlData | input | 3 | New DF, IF, TF values |
| result | output | 32 | Combinational result, zero above the active width |
| flagsWord | output | 16 | Registered flags word |

## Verification
`result` has no register in its path, so the bench checks it 1 ns after driving the inputs on the falling edge, in the same cycle. The flags pass through exactly one register, so each flag is checked 1 ns after the next rising edge. It is compared against a behavioural model that advances at that same edge. Each operation therefore has one due point for its result and one for its flags. Stimulus with `opValid` low, zero shift counts and control loads is compared at the same flag due point, which shows both holding and updating.

// File: rtl/sfuPkg.sv
package sfuPkg;
  localparam int NUM_SIZES = 3;
  localparam int SIZE_IDX_W = 2;
  localparam int FLAGS_W = 16;

  localparam int FL_CF = 0;
  localparam int FL_PF = 2;
  localparam int FL_AF = 4;
  localparam int FL_ZF = 6;
  localparam int FL_SF = 7;
  localparam int FL_TF = 8;
  localparam int FL_IF = 9;
  localparam int FL_DF = 10;
  localparam int FL_OF = 11;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_SHL = 2'b10,
    OP_SHR = 2'b11
  } opKind_e;

  typedef struct packed {
    logic selAdd;
    logic selSub;
    logic selShl;
    logic selShr;
    logic [SIZE_IDX_W-1:0] sizeIdx;
    logic updArith;
    logic loadCtl;
  } strobes_t;
endpackage

// File: rtl/sfuControl.sv
module sfuControl
  import sfuPkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             opValid,
  input  logic [1:0]       opCode,
  input  logic [1:0]       opSize,
  input  logic [CNT_W-1:0] shiftCnt,
  input  logic             ctlLoad,
  output strobes_t         st
);
  logic isShift;

  always_comb begin
    st = '0;
    unique case (opKind_e'(opCode))
      OP_ADD: st.selAdd = 1'b1;
      OP_SUB: st.selSub = 1'b1;
      OP_SHL: st.selShl = 1'b1;
      default: st.selShr = 1'b1;
    endcase
    isShift = st.selShl | st.selShr;
    // widths above the largest lane fold onto the widest lane
    if (int'(opSize) >= NUM_SIZES) st.sizeIdx = SIZE_IDX_W'(NUM_SIZES - 1);
    else st.sizeIdx = SIZE_IDX_W'(opSize);
    st.updArith = opValid && !(isShift && (shiftCnt == '0));
    st.loadCtl = ctlLoad;
  end

  always_comb begin
    assert_one_op_R2: assert ($onehot({st.selAdd, st.selSub, st.selShl, st.selShr}));
  end
endmodule

// File: rtl/sfuDatapath.sv
module sfuDatapath
  import sfuPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           st,
  input  logic [DATA_W-1:0]  srcA,
  input  logic [DATA_W-1:0]  srcB,
  input  logic [2:0]         ctlData,
  output logic [DATA_W-1:0]  result,
  output logic [FLAGS_W-1:0] flagsWord
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0] cnt;
  assign cnt = srcB[CNT_W-1:0];

  logic [DATA_W-1:0] laneRes [NUM_SIZES];
  logic laneCf [NUM_SIZES];
  logic laneOf [NUM_SIZES];
  logic laneAf [NUM_SIZES];
  logic laneSf [NUM_SIZES];
  logic laneZf [NUM_SIZES];
  logic lanePf [NUM_SIZES];

  for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : gLane
    localparam int W = 8 << gi;
    logic [W-1:0]   a, b, r;
    logic [W:0]     sum, diff, shrExt;
    logic [2*W-1:0] shlExt;

    assign a = srcA[W-1:0];
    assign b = srcB[W-1:0];
    assign sum = {1'b0, a} + {1'b0, b};
    assign diff = {1'b0, a} - {1'b0, b};
    assign shlExt = {{W{1'b0}}, a} << cnt;
    assign shrExt = {a, 1'b0} >> cnt;

    always_comb begin
      if (st.selAdd)      r = sum[W-1:0];
      else if (st.selSub) r = diff[W-1:0];
      else if (st.selShl) r = shlExt[W-1:0];
      else                r = shrExt[W:1];
    end

    assign laneRes[gi] = DATA_W'(r);
    assign laneCf[gi] = st.selAdd ? sum[W] : st.selSub ? diff[W] : st.selShl ? shlExt[W] : shrExt[0];
    assign laneOf[gi] = (st.selAdd && (a[W-1] == b[W-1]) && (r[W-1] != a[W-1])) ||
                        (st.selSub && (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]));
    assign laneAf[gi] = (st.selAdd || st.selSub) && (a[4] ^ b[4] ^ r[4]);
    assign laneSf[gi] = r[W-1];
    assign laneZf[gi] = (r == '0);
    assign lanePf[gi] = ^r;
  end

  logic pickCf, pickOf, pickAf, pickSf, pickZf, pickPf;

  always_comb begin
    result = laneRes[NUM_SIZES-1];
    pickCf = laneCf[NUM_SIZES-1];
    pickOf = laneOf[NUM_SIZES-1];
    pickAf = laneAf[NUM_SIZES-1];
    pickSf = laneSf[NUM_SIZES-1];
    pickZf = laneZf[NUM_SIZES-1];
    pickPf = lanePf[NUM_SIZES-1];
    for (int i = 0; i < NUM_SIZES - 1; i++) begin
      if (int'(st.sizeIdx) == i) begin
        result = laneRes[i];
        pickCf = laneCf[i];
        pickOf = laneOf[i];
        pickAf = laneAf[i];
        pickSf = laneSf[i];
        pickZf = laneZf[i];
        pickPf = lanePf[i];
      end
    end
  end

  logic [FLAGS_W-1:0] flagsQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else begin
      if (st.updArith) begin
        flagsQ[FL_OF] <= pickOf;
        flagsQ[FL_SF] <= pickSf;
        flagsQ[FL_ZF] <= pickZf;
        flagsQ[FL_AF] <= pickAf;
        flagsQ[FL_PF] <= pickPf;
        flagsQ[FL_CF] <= pickCf;
      end
      if (st.loadCtl) begin
        flagsQ[FL_DF] <= ctlData[2];
        flagsQ[FL_IF] <= ctlData[1];
        flagsQ[FL_TF] <= ctlData[0];
      end
    end
  end

  assign flagsWord = flagsQ;

  logic [5:0] arithBits;
  assign arithBits = {flagsQ[FL_OF], flagsQ[FL_SF], flagsQ[FL_ZF],
                      flagsQ[FL_AF], flagsQ[FL_PF], flagsQ[FL_CF]};

  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ[1] == 1'b0) && (flagsQ[3] == 1'b0) && (flagsQ[5] == 1'b0) && (flagsQ[15:12] == 4'h0));

  assert_ctl_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !st.loadCtl |=> $stable(flagsQ[FL_DF:FL_TF]));

  assert_arith_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !st.updArith |=> $stable(arithBits));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.updArith |=> flagsQ[FL_ZF] == ($past(result) == '0));

  assert_parity_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.updArith |=> flagsQ[FL_PF] == $past(^result));
endmodule

// File: rtl/statusFlagUnit.sv
module statusFlagUnit
  import sfuPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opCode,
  input  logic [1:0]        opSize,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic              ctlLoad,
  input  logic [2:0]        ctlData,
  output logic [DATA_W-1:0] result,
  output logic [15:0]       flagsWord
);
  localparam int CNT_W = $clog2(DATA_W);

  strobes_t st;

  sfuControl #(.CNT_W(CNT_W)) uCtl (
    .opValid (opValid),
    .opCode  (opCode),
    .opSize  (opSize),
    .shiftCnt(srcB[CNT_W-1:0]),
    .ctlLoad (ctlLoad),
    .st      (st)
  );

  sfuDatapath #(.DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .srcA     (srcA),
    .srcB     (srcB),
    .ctlData  (ctlData),
    .result   (result),
    .flagsWord(flagsWord)
  );
endmodule

// File: tb/test_statusFlagUnit.sv
module test_statusFlagUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opCode = 2'b00;
  logic [1:0]  opSize = 2'b00;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic        ctlLoad = 1'b0;
  logic [2:0]  ctlData = 3'b000;
  logic [31:0] result;
  logic [15:0] flagsWord;

  int tests = 0;
  int fails = 0;

  // behavioural model state
  bit mOf, mSf, mZf, mAf, mPf, mCf, mDf, mIf, mTf;

  statusFlagUnit i_statusFlagUnit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opSize(opSize),
    .srcA(srcA), .srcB(srcB), .ctlLoad(ctlLoad), .ctlData(ctlData),
    .result(result), .flagsWord(flagsWord)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkFlags(input string ctx);
    chk({"R4 OF ", ctx}, flagsWord[11], mOf);
    chk({"R5 SF ", ctx}, flagsWord[7], mSf);
    chk({"R5 ZF ", ctx}, flagsWord[6], mZf);
    chk({"R6 AF ", ctx}, flagsWord[4], mAf);
    chk({"R7 PF ", ctx}, flagsWord[2], mPf);
    chk({"R3 CF ", ctx}, flagsWord[0], mCf);
    chk({"R11 DF/IF/TF ", ctx}, flagsWord[10:8], {mDf, mIf, mTf});
    chk({"R8 unused bits ", ctx}, {flagsWord[15:12], flagsWord[5], flagsWord[3], flagsWord[1]}, 0);
  endtask

  task automatic step(input int op, input int sz, input longint a, input longint b,
                      input bit v, input bit ld, input int ldv);
    longint w, mask, am, bm, r, c, s;
    bit cf, of, af, upd;
    string ctx;
    @(negedge clk);
    opCode = 2'(op); opSize = 2'(sz); srcA = 32'(a); srcB = 32'(b);
    opValid = v; ctlLoad = ld; ctlData = 3'(ldv);
    #1;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (64'sd1 <<< w) - 1;
    am = a & mask; bm = b & mask; c = b & 31;
    cf = 0; of = 0; af = 0;
    case (op)
      0: begin
        s = am + bm; r = s & mask; cf = ((s >>> w) & 1) != 0;
        af = ((am & 15) + (bm & 15)) > 15;
        of = (am[w-1] == bm[w-1]) && (r[w-1] != am[w-1]);
      end
      1: begin
        r = (am - bm) & mask; cf = am < bm;
        af = (am & 15) < (bm & 15);
        of = (am[w-1] != bm[w-1]) && (r[w-1] != am[w-1]);
      end
      2: begin
        r = (am <<< c) & mask;
        cf = (c != 0) && (c <= w) && (((am >>> (w - c)) & 1) != 0);
      end
      default: begin
        r = am >>> c;
        cf = (c != 0) && (((am >>> (c - 1)) & 1) != 0);
      end
    endcase
    chk($sformatf("R2 result op=%0d size=%0d", op, sz), result, r);
    upd = v && !(op >= 2 && c == 0);
    if (upd) begin
      mOf = of; mCf = cf; mAf = af;
      mSf = r[w-1]; mZf = (r == 0); mPf = ($countones(r) % 2) == 1;
      ctx = $sformatf("R9 update op=%0d size=%0d", op, sz);
    end else if (v) ctx = "R10 zero-count shift holds";
    else ctx = "R9 hold without opValid";
    if (ld) {mDf, mIf, mTf} = 3'(ldv);
    @(posedge clk); #1;
    checkFlags(ctx);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset word", flagsWord, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", flagsWord, 0);
    // directed corners
    step(0, 0, 'h7F, 'h01, 1, 0, 0);        // signed overflow, nibble carry
    step(0, 0, 'hFF, 'h01, 1, 0, 0);        // carry out, zero
    step(1, 1, 'h0000, 'h0001, 1, 0, 0);    // borrow, 16 ones
    step(1, 2, 'h80000000, 1, 1, 0, 0);     // subtract overflow
    step(2, 0, 'h81, 1, 1, 0, 0);           // shl last bit out
    step(2, 0, 'hFF, 20, 1, 0, 0);          // count past width
    step(3, 2, 'h00000003, 1, 1, 0, 0);     // shr last bit out
    step(3, 3, 'h12345678, 0, 1, 0, 0);     // R10 zero count
    step(0, 0, 'h00, 'h00, 0, 0, 0);        // R9 opValid low
    step(0, 1, 'hFFFF, 1, 1, 1, 5);         // R11 load with arithmetic
    step(1, 0, 'h10, 'h01, 1, 0, 0);        // R11 control bits hold
    step(0, 2, 'hFFFFFFFF, 'hFFFFFFFF, 1, 1, 2);
    // random sweep
    for (int k = 0; k < 2000; k++) begin
      step($urandom_range(0, 3), $urandom_range(0, 3), longint'($urandom), longint'($urandom),
           $urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0, $urandom_range(0, 7));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule